// File: doc/BRIEF.md
# Register-Write Microcode Encoder

This block turns a stream of commands into a compact, byte-oriented microcode image for a hardware sequencer. The most common command asks for "write value V to register A". The encoder remembers the last address and the last value it placed in the image. A value that repeats is left out, and a value or address whose upper half matches the remembered one is written in a short 16-bit form. Two other commands place a single opcode byte or a three-byte wait instruction into the image.

A finish command closes the image. It pads the image with end-of-code bytes up to a whole number of 32-bit words, reports the padded length and returns the write pointer to the start of the buffer. The bytes go out through a simple write port, one byte per clock, into a local buffer. A restart command clears the pointer, both trackers and the flags. A command that would run past the end of the buffer is dropped, and a sticky overflow flag is raised.

Top module: `ucode_packer`

## Requirements
- R1: After reset, `req_ready` is 1, `buf_we` is 0, `ucode_len` is 0, and `done` and `overflow` are 0.
- R2: Both trackers start at all-ones, so the first write (kind 1) after reset or restart with a value other than all-ones emits 0xE2, the value as 4 bytes with the least significant byte first, then 0xE0 and the address as 4 bytes with the least significant byte first.
- R3: A write (kind 1) whose value equals the last emitted value emits no value bytes. Only the address form is emitted.
- R4: A write whose value differs from the last value only in its low 16 bits emits 0x42 and the low 16 bits (low byte first) as its value form.
- R5: The address form is always emitted and always follows the value form. When the upper 16 address bits match the last address, the form is 0x40 and the low 16 bits (low byte first).
- R6: A raw command (kind 2) emits exactly one byte, equal to `req_op`.
- R7: A wait command (kind 3) emits 0x5F, then `req_op`, then `req_arg`.
- R8: A finish command (kind 4) appends between 1 and 4 bytes of 0x7F, as many as bring the pointer to a multiple of 4. It then sets `done`, sets `ucode_len` to the padded byte count and returns the pointer to 0. The trackers keep their values.
- R9: Bytes go out one per cycle, at consecutive buffer addresses starting at the current pointer. `req_ready` stays low while a command is being emitted.
- R10: A command whose bytes would run past `CAP_BYTES` is dropped. It writes no byte, leaves the trackers and the pointer unchanged, and sets `overflow`, which stays set until a restart.
- R11: A restart command (kind 0) writes nothing. It returns the pointer to 0, sets both trackers to all-ones, and clears `ucode_len`, `done` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Encoder idle; a command is taken on valid and ready |
| req_kind | input | 3 | 0 restart, 1 write, 2 raw, 3 wait, 4 finish |
| req_addr | input | 32 | Register address for a write |
| req_data | input | 32 | Register value for a write |
| req_op | input | 8 | Raw opcode, or first wait argument |
| req_arg | input | 8 | Second wait argument |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | $clog2(CAP_BYTES) | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| ucode_len | output | $clog2(CAP_BYTES+1) | Padded image length after finish |
| done | output | 1 | Image closed by finish |
| overflow | output | 1 | Sticky: a command was dropped for lack of room |

## Verification
The hardest case to reach is the overflow boundary. A command must be offered when the free space is smaller than that command but larger than a later, shorter one. The stimulus fills the buffer with single raw bytes to four bytes short of the end. It then offers a ten-byte write, which must be dropped. Next comes a three-byte short-address write. It is short only if the dropped write left the trackers untouched, and it must fit. A final finish then pads exactly one byte, so the reported length is the full capacity.

// File: rtl/ucpk_pkg.sv
// Package: shared command kinds and opcode bytes of the microcode encoder.
// Assumes the sequencer decodes the opcode values listed here.
package ucpk_pkg;

    typedef enum logic [2:0] {
        CMD_INIT   = 3'd0,
        CMD_WRITE  = 3'd1,
        CMD_RAW    = 3'd2,
        CMD_WAIT   = 3'd3,
        CMD_FINISH = 3'd4
    } cmd_e;

    localparam logic [7:0] OP_VAL_SHORT = 8'h42;
    localparam logic [7:0] OP_VAL_LONG  = 8'hE2;
    localparam logic [7:0] OP_ADR_SHORT = 8'h40;
    localparam logic [7:0] OP_ADR_LONG  = 8'hE0;
    localparam logic [7:0] OP_WAIT      = 8'h5F;
    localparam logic [7:0] OP_PAD       = 8'h7F;

    // Longest single emission: long value form plus long address form.
    localparam int MAX_EMIT = 10;

endpackage

// File: rtl/ucpk_tracker.sv
// Module: holds the last emitted word of one kind (address or value).
// Assumes: clear and load are never high together; clear wins if they are.
module ucpk_tracker #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    // Remember the last committed word; all-ones means "nothing emitted".
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            q <= '1;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/ucpk_planner.sv
// Module: combinational planner that turns one command into its byte list.
// Assumes: the trackers hold the last emitted address and value; ptr_lo is
// the low two bits of the current write pointer. Unused slots read as 0x7F.
module ucpk_planner
    import ucpk_pkg::*;
#(
    parameter int NB = MAX_EMIT,
    localparam int LW = $clog2(NB + 1)
) (
    input  cmd_e                kind,
    input  logic [31:0]         addr,
    input  logic [31:0]         data,
    input  logic [7:0]          op,
    input  logic [7:0]          arg,
    input  logic [31:0]         last_adr,
    input  logic [31:0]         last_val,
    input  logic [1:0]          ptr_lo,
    output logic [NB-1:0][7:0]  seq,
    output logic [LW-1:0]       seq_len
);

    logic [7:0][7:0] vseg;
    logic [7:0][7:0] aseg;
    logic [2:0]      vlen;
    logic [2:0]      alen;
    logic [NB-1:0][7:0] wr_seq;

    // Value form: skipped on a repeat, short on an upper-half match.
    always_comb begin
        vseg = {8{OP_PAD}};
        vlen = 3'd0;
        if (data != last_val) begin
            if (data[31:16] == last_val[31:16]) begin
                vseg[0] = OP_VAL_SHORT;
                vseg[1] = data[7:0];
                vseg[2] = data[15:8];
                vlen    = 3'd3;
            end else begin
                vseg[0] = OP_VAL_LONG;
                vseg[1] = data[7:0];
                vseg[2] = data[15:8];
                vseg[3] = data[23:16];
                vseg[4] = data[31:24];
                vlen    = 3'd5;
            end
        end
    end

    // Address form: always present, short on an upper-half match.
    always_comb begin
        aseg = {8{OP_PAD}};
        if (addr[31:16] == last_adr[31:16]) begin
            aseg[0] = OP_ADR_SHORT;
            aseg[1] = addr[7:0];
            aseg[2] = addr[15:8];
            alen    = 3'd3;
        end else begin
            aseg[0] = OP_ADR_LONG;
            aseg[1] = addr[7:0];
            aseg[2] = addr[15:8];
            aseg[3] = addr[23:16];
            aseg[4] = addr[31:24];
            alen    = 3'd5;
        end
    end

    // Concatenate the value form and the address form, value first.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            logic [3:0] j;
            j = 4'(i) - {1'b0, vlen};
            if (4'(i) < {1'b0, vlen}) begin
                wr_seq[i] = vseg[3'(i)];
            end else if (j < {1'b0, alen}) begin
                wr_seq[i] = aseg[j[2:0]];
            end else begin
                wr_seq[i] = OP_PAD;
            end
        end
    end

    // Pick the byte list and its length by command kind.
    always_comb begin
        seq     = {NB{OP_PAD}};
        seq_len = '0;
        unique case (kind)
            CMD_WRITE: begin
                seq     = wr_seq;
                seq_len = LW'(vlen) + LW'(alen);
            end
            CMD_RAW: begin
                seq[0]  = op;
                seq_len = LW'(1);
            end
            CMD_WAIT: begin
                seq[0]  = OP_WAIT;
                seq[1]  = op;
                seq[2]  = arg;
                seq_len = LW'(3);
            end
            CMD_FINISH: begin
                seq_len = LW'(3'd4 - {1'b0, ptr_lo});
            end
            default: begin
                seq_len = '0;
            end
        endcase
    end

endmodule

// File: rtl/ucpk_emitter.sv
// Module: accepts commands, checks room, and streams planned bytes into the
// buffer one per cycle. Owns the pointer, length, done and overflow state.
// Assumes: the planner output is valid in the cycle a command is offered.
module ucpk_emitter
    import ucpk_pkg::*;
#(
    parameter int CAP_BYTES = 512,
    parameter int NB        = MAX_EMIT,
    localparam int AW = $clog2(CAP_BYTES),
    localparam int PW = $clog2(CAP_BYTES + 1),
    localparam int LW = $clog2(NB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  cmd_e               kind,
    input  logic [NB-1:0][7:0] seq,
    input  logic [LW-1:0]      seq_len,
    output logic [PW-1:0]      ptr,
    output logic               trk_clear,
    output logic               trk_load,
    output logic               buf_we,
    output logic [AW-1:0]      buf_addr,
    output logic [7:0]         buf_wdata,
    output logic [PW-1:0]      ucode_len,
    output logic               done,
    output logic               overflow
);

    logic               busy;
    logic               fin_run;
    logic [NB-1:0][7:0] stage;
    logic [LW-1:0]      stage_n;
    logic [LW-1:0]      idx;
    logic [PW:0]        need;
    logic               fits;
    logic               fire;
    logic               is_init;
    logic               last_byte;

    // Decide whether the offered command is taken, restarts, or is dropped.
    always_comb begin
        fire      = req_valid && req_ready;
        is_init   = (kind == CMD_INIT);
        need      = {1'b0, ptr} + (PW + 1)'(seq_len);
        fits      = (need <= (PW + 1)'(CAP_BYTES));
        trk_clear = fire && is_init;
        trk_load  = fire && (kind == CMD_WRITE) && fits;
        last_byte = busy && (idx == stage_n - LW'(1));
    end

    // Drive the buffer port from the staged byte list.
    always_comb begin
        req_ready = !busy;
        buf_we    = busy;
        buf_addr  = ptr[AW-1:0];
        buf_wdata = stage[idx];
    end

    // Sequence emission, pointer movement, finish bookkeeping and overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            fin_run   <= 1'b0;
            stage     <= '0;
            stage_n   <= '0;
            idx       <= '0;
            ptr       <= '0;
            ucode_len <= '0;
            done      <= 1'b0;
            overflow  <= 1'b0;
        end else if (busy) begin
            idx <= idx + LW'(1);
            ptr <= ptr + PW'(1);
            if (last_byte) begin
                busy <= 1'b0;
                if (fin_run) begin
                    ptr       <= '0;
                    ucode_len <= ptr + PW'(1);
                    done      <= 1'b1;
                end
            end
        end else if (fire) begin
            if (is_init) begin
                ptr       <= '0;
                ucode_len <= '0;
                done      <= 1'b0;
                overflow  <= 1'b0;
            end else if (!fits) begin
                overflow <= 1'b1;
            end else begin
                stage   <= seq;
                stage_n <= seq_len;
                idx     <= '0;
                fin_run <= (kind == CMD_FINISH);
                busy    <= (seq_len != '0);
                done    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ucode_packer.sv
// Module: top of the register-write microcode encoder. Wires the planner,
// the two trackers and the emitter together.
// Assumes: CAP_BYTES is a multiple of 4 and at least MAX_EMIT.
module ucode_packer
    import ucpk_pkg::*;
#(
    parameter int CAP_BYTES = 512,
    localparam int AW = $clog2(CAP_BYTES),
    localparam int PW = $clog2(CAP_BYTES + 1),
    localparam int LW = $clog2(MAX_EMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_kind,
    input  logic [31:0]   req_addr,
    input  logic [31:0]   req_data,
    input  logic [7:0]    req_op,
    input  logic [7:0]    req_arg,
    output logic          buf_we,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    buf_wdata,
    output logic [PW-1:0] ucode_len,
    output logic          done,
    output logic          overflow
);

    cmd_e                     kind;
    logic [31:0]              last_adr;
    logic [31:0]              last_val;
    logic [MAX_EMIT-1:0][7:0] seq;
    logic [LW-1:0]            seq_len;
    logic [PW-1:0]            ptr;
    logic                     trk_clear;
    logic                     trk_load;
    logic [1:0][31:0]         trk_in;
    logic [1:0][31:0]         trk_q;

    // Interpret the raw kind field as a command.
    always_comb begin
        kind      = cmd_e'(req_kind);
        trk_in[0] = req_addr;
        trk_in[1] = req_data;
        last_adr  = trk_q[0];
        last_val  = trk_q[1];
    end

    // One tracker for the address, one for the value.
    for (genvar g = 0; g < 2; g++) begin : g_trk
        ucpk_tracker #(.W(32)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (trk_clear),
            .load  (trk_load),
            .din   (trk_in[g]),
            .q     (trk_q[g])
        );
    end

    ucpk_planner #(.NB(MAX_EMIT)) u_plan (
        .kind     (kind),
        .addr     (req_addr),
        .data     (req_data),
        .op       (req_op),
        .arg      (req_arg),
        .last_adr (last_adr),
        .last_val (last_val),
        .ptr_lo   (ptr[1:0]),
        .seq      (seq),
        .seq_len  (seq_len)
    );

    ucpk_emitter #(.CAP_BYTES(CAP_BYTES), .NB(MAX_EMIT)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .kind      (kind),
        .seq       (seq),
        .seq_len   (seq_len),
        .ptr       (ptr),
        .trk_clear (trk_clear),
        .trk_load  (trk_load),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata),
        .ucode_len (ucode_len),
        .done      (done),
        .overflow  (overflow)
    );

endmodule

// File: rtl/ucpk_checker.sv
// Module: port-level protocol checks for ucode_packer, attached by bind.
// Assumes: synchronous active-low reset; all checks are off during reset.
module ucpk_checker #(
    parameter int AW = 9,
    parameter int PW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          buf_we,
    input logic [AW-1:0] buf_addr,
    input logic [7:0]    buf_wdata,
    input logic [PW-1:0] ucode_len,
    input logic          done,
    input logic          overflow
);

    // R9
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !req_ready);

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 1'b1));

    // R8
    done_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (ucode_len[1:0] == 2'b00 && $past(buf_we) && $past(buf_wdata) == 8'h7F));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !buf_we);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(req_valid && req_ready) && !buf_we));

endmodule

bind ucode_packer ucpk_checker #(.AW(AW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .ucode_len (ucode_len),
    .done      (done),
    .overflow  (overflow)
);

// File: tb/tb_ucode_packer.sv
`timescale 1ns/1ps
// Directed bench for ucode_packer: one task per scenario, each self-checking.
module tb_ucode_packer;

    localparam int CAP = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [7:0]  req_op = '0;
    logic [7:0]  req_arg = '0;
    logic        buf_we;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_wdata;
    logic [9:0]  ucode_len;
    logic        done;
    logic        overflow;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wcount = 0;
    int ready_bad = 0;
    logic [7:0] mem [0:CAP-1];

    logic [7:0]  exb [0:15];
    int          exn;
    logic [31:0] m_val = 32'hFFFF_FFFF;
    logic [31:0] m_adr = 32'hFFFF_FFFF;
    int          m_ptr = 0;

    always #4 clk = ~clk;

    ucode_packer #(.CAP_BYTES(CAP)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_op    (req_op),
        .req_arg   (req_arg),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata),
        .ucode_len (ucode_len),
        .done      (done),
        .overflow  (overflow)
    );

    // Capture buffer writes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            mem[buf_addr] = buf_wdata;
            wcount++;
            if (req_ready) ready_bad++;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        exb[exn] = b;
        exn++;
    endtask

    // Expected bytes of a write, from the requirements.
    task automatic model_write(input logic [31:0] a, input logic [31:0] d);
        exn = 0;
        if (d != m_val) begin
            if (d[31:16] == m_val[31:16]) begin
                push(8'h42); push(d[7:0]); push(d[15:8]);
            end else begin
                push(8'hE2); push(d[7:0]); push(d[15:8]); push(d[23:16]); push(d[31:24]);
            end
        end
        if (a[31:16] == m_adr[31:16]) begin
            push(8'h40); push(a[7:0]); push(a[15:8]);
        end else begin
            push(8'hE0); push(a[7:0]); push(a[15:8]); push(a[23:16]); push(a[31:24]);
        end
    endtask

    task automatic send(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d,
                        input logic [7:0] o, input logic [7:0] g);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_kind = k; req_addr = a; req_data = d; req_op = o; req_arg = g;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    // Send a command and compare the bytes written with exb/exn.
    task automatic send_expect(input string req, input logic [2:0] k, input logic [31:0] a,
                               input logic [31:0] d, input logic [7:0] o, input logic [7:0] g);
        int w0;
        int mis;
        int first_i;
        w0 = wcount;
        mis = 0;
        first_i = 0;
        send(k, a, d, o, g);
        chk(wcount - w0 == exn, {req, " byte count"}, wcount - w0, exn);
        for (int i = 0; i < exn; i++) begin
            if (mem[(m_ptr + i) % CAP] !== exb[i]) begin
                if (mis == 0) first_i = i;
                mis++;
            end
        end
        chk(mis == 0, {req, " bytes"}, mem[(m_ptr + first_i) % CAP], exb[first_i]);
        m_ptr = m_ptr + exn;
    endtask

    task automatic do_write(input string req, input logic [31:0] a, input logic [31:0] d);
        model_write(a, d);
        send_expect(req, 3'd1, a, d, 8'h00, 8'h00);
        m_val = d;
        m_adr = a;
    endtask

    task automatic do_finish(input string req);
        int pad;
        pad = 4 - (m_ptr % 4);
        exn = 0;
        for (int i = 0; i < pad; i++) push(8'h7F);
        send_expect(req, 3'd4, '0, '0, 8'h00, 8'h00);
        chk(ucode_len == 10'(m_ptr), {req, " length"}, ucode_len, m_ptr);
        chk(done == 1'b1, {req, " done"}, done, 1);
        m_ptr = 0;
    endtask

    task automatic do_init();
        send(3'd0, '0, '0, 8'h00, 8'h00);
        m_ptr = 0;
        m_val = 32'hFFFF_FFFF;
        m_adr = 32'hFFFF_FFFF;
    endtask

    task automatic t_reset();
        // R1
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(buf_we == 1'b0, "R1 buf_we", buf_we, 0);
        chk(ucode_len == '0 && done == 1'b0 && overflow == 1'b0, "R1 len/done/overflow",
            {ucode_len, done, overflow}, 0);
    endtask

    task automatic t_writes();
        do_write("R2 first write long forms", 32'h0010_0210, 32'h8000_0000);
        do_write("R3 repeated value", 32'h0010_0214, 32'h8000_0000);
        do_write("R4 short value", 32'h0020_0000, 32'h8000_1234);
        do_write("R5 short address after short value", 32'h0020_0abc, 32'h8000_5678);
        chk(ready_bad == 0, "R9 ready low while emitting", ready_bad, 0);
    endtask

    task automatic t_raw_wait();
        exn = 0; push(8'hB0);
        send_expect("R6 raw byte", 3'd2, '0, '0, 8'hB0, 8'h00);
        exn = 0; push(8'h5F); push(8'h03); push(8'h01);
        send_expect("R7 wait", 3'd3, '0, '0, 8'h03, 8'h01);
    endtask

    task automatic t_finish();
        do_finish("R8 finish pad");
        // R8: next command lands at address 0 with trackers kept
        do_write("R8 restart at zero", 32'h0020_0004, 32'h8000_5678);
        exn = 0; push(8'h07);
        send_expect("R8 raw to align", 3'd2, '0, '0, 8'h07, 8'h00);
        do_finish("R8 aligned finish pads four");
    endtask

    task automatic t_init();
        do_write("R11 prior write", 32'h0033_0000, 32'h0000_0001);
        do_init();
        chk(ucode_len == '0 && done == 1'b0, "R11 len/done cleared", {ucode_len, done}, 0);
        // all-ones value is suppressed after restart: trackers reset
        do_write("R11 trackers reset", 32'h0000_0000, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow();
        int w0;
        do_init();
        for (int i = 0; i < CAP - 4; i++) begin
            send(3'd2, '0, '0, 8'(i), 8'h00);
        end
        m_ptr = CAP - 4;
        chk(mem[CAP - 5] == 8'(CAP - 5), "R10 fill data", mem[CAP - 5], 8'(CAP - 5));
        w0 = wcount;
        send(3'd1, 32'h1234_5678, 32'hCAFE_F00D, 8'h00, 8'h00);
        chk(wcount == w0, "R10 dropped writes nothing", wcount - w0, 0);
        chk(overflow == 1'b1, "R10 overflow set", overflow, 1);
        do_write("R10 trackers untouched", 32'hFFFF_0010, 32'hFFFF_FFFF);
        chk(overflow == 1'b1, "R10 overflow sticky", overflow, 1);
        do_finish("R10 finish at capacity");
        do_init();
        chk(overflow == 1'b0, "R11 overflow cleared", overflow, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_writes();
        t_raw_wait();
        t_finish();
        t_init();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule